// File: doc/BRIEF.md
# Sonar Ping and Depth Counter Controller

This block runs the digital side of a small ultrasonic depth sounder. When switched on, it repeats a fixed cycle: it waits, then raises a transmit enable so that an external burst generator drives the transducer, then listens for the returning echo. A cascaded decimal (BCD) counter starts at the beginning of each ping and counts reference-clock ticks. The clock is chosen so that one tick equals one foot of depth. When a synchronised echo edge arrives during the listen phase, the counter value is latched as the new reading.

The reading drives three common-anode seven-segment digits, so every segment output is active low. It is shown either in feet or in meters. Meters are the foot count scaled by 0.3048 and rounded to the nearest integer. Leading zeros are blanked. A listen phase that ends with no echo replaces the reading with a dash pattern. Two pushbuttons control the block. One switches it on and off. The other swaps the display unit, and two active-low LEDs show which unit is selected. Both buttons are synchronised, debounced and edge-detected. The echo input is synchronised.

Top module: `sonar_depth_ctrl`

## Requirements
- R1: After reset the block is switched off: `tx_en_o` is low, all 21 segment lines are high (dark) and both unit LEDs are high (dark). While off, the outputs stay in this state.
- R2: A power press while off switches the block on into the wait phase. A power press during the wait phase switches it off. A power press during transmit or listen has no effect.
- R3: A unit press while on toggles between feet and meters. The lit LED moves: `led_ft_n_o`=0 for feet, `led_m_n_o`=0 for meters. A unit press while off is ignored, and the unit stays feet after reset.
- R4: The wait phase lasts LONG_TICKS cycles, and then the transmit phase starts. `tx_en_o` is high for exactly SHORT_TICKS consecutive cycles, and at no other time.
- R5: The depth counter reads 0 in the first transmit cycle and adds one each cycle, saturating at 999. The echo passes through two synchroniser flops and one edge flop. A rising echo edge seen during listen latches the counter value and returns the block to the wait phase. An echo raised in the cycle where the transmit-phase count equals D therefore reads D+2.
- R6: Echo edges that arrive outside the listen phase are ignored.
- R7: A listen phase of LONG_TICKS cycles with no echo returns the block to the wait phase in error mode. In error mode each digit shows only segment g lit (value 7'b0111111). The next valid echo clears error mode.
- R8: Segment bus layout: bits [6:0] hold the ones digit, bits [13:7] the tens digit and bits [20:14] the hundreds digit. Within a digit, bit 0 is segment a and bit 6 is segment g, and all lines are active low. Leading zero digits are dark (7'h7F), and the ones digit is always shown.
- R9: In meters mode the value shown is floor((feet*3048+5000)/10000).
- R10: A button input must be high for DB_TICKS consecutive cycles after its two synchroniser flops before it counts as a press. Each press causes exactly one action, and a shorter pulse causes none.
- R11: Switching on clears the reading to 0 and clears error mode. The unit in use before switching off is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, one tick per foot of depth |
| rst_i | input | 1 | Synchronous reset, active high |
| pwr_btn_i | input | 1 | Raw on/off pushbutton, high when pressed |
| unit_btn_i | input | 1 | Raw feet/meters pushbutton, high when pressed |
| echo_i | input | 1 | Asynchronous echo detect from the receiver, high on echo |
| tx_en_o | output | 1 | Enable for the external burst generator |
| seg_n_o | output | 21 | Active-low segment lines for three digits |
| led_ft_n_o | output | 1 | Active-low feet indicator |
| led_m_n_o | output | 1 | Active-low meters indicator |

## Verification
Some properties are checked on every cycle. The block must be dark whenever it is off. Exactly one unit LED must be lit whenever it is on. Each transmit burst must last SHORT_TICKS cycles and must follow a wait phase. Error mode must always show the dash pattern. The power-off path may only leave from the wait phase. The values of the latched readings, the rounding used for meters, the blanking of leading zeros, the rejection of echoes during transmit, and the rejection of short button glitches only become visible in bench scenarios. There, a behavioural reference model and targeted checks set exact echo timings against the displayed digits.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int SDC_DIGITS = 3;
    localparam int SEG_W      = 7;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_SEND = 2'd2,
        ST_RECV = 2'd3
    } sdc_state_e;

    typedef logic [SDC_DIGITS-1:0][3:0] bcd_num_t;

    localparam logic [SEG_W-1:0] SEG_BLANK_N = 7'h7F;
    localparam logic [SEG_W-1:0] SEG_DASH_N  = 7'b0111111;

    // active-low pattern, bit 0 = segment a
    function automatic logic [SEG_W-1:0] seg_of(input logic [3:0] d);
        logic [SEG_W-1:0] on;
        case (d)
            4'd0: on = 7'h3F;
            4'd1: on = 7'h06;
            4'd2: on = 7'h5B;
            4'd3: on = 7'h4F;
            4'd4: on = 7'h66;
            4'd5: on = 7'h6D;
            4'd6: on = 7'h7D;
            4'd7: on = 7'h07;
            4'd8: on = 7'h7F;
            4'd9: on = 7'h6F;
            default: on = 7'h00;
        endcase
        return ~on;
    endfunction

    function automatic int bcd_to_int(input bcd_num_t v);
        int acc;
        acc = 0;
        for (int i = SDC_DIGITS - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(v[i]);
        end
        return acc;
    endfunction

    function automatic bcd_num_t int_to_bcd(input int n);
        bcd_num_t r;
        int rest;
        rest = n;
        for (int i = 0; i < SDC_DIGITS; i++) begin
            r[i] = 4'(rest % 10);
            rest = rest / 10;
        end
        return r;
    endfunction

    function automatic bcd_num_t feet_to_meters(input bcd_num_t ft);
        int f;
        f = bcd_to_int(ft);
        return int_to_bcd((f * 3048 + 5000) / 10000);
    endfunction

endpackage

// File: rtl/sdc_sync2.sv
module sdc_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/sdc_debounce.sv
module sdc_debounce #(
    parameter int DB_TICKS = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic press_o
);
    localparam int CW = $clog2(DB_TICKS) + 1;

    typedef struct packed {
        logic          stable;
        logic [CW-1:0] cnt;
    } db_reg_t;

    db_reg_t r_d, r_q;
    logic    settle;

    always_comb begin
        r_d    = r_q;
        settle = (level_i != r_q.stable) && (r_q.cnt == CW'(DB_TICKS - 1));
        if (level_i != r_q.stable) begin
            if (settle) begin
                r_d.stable = level_i;
                r_d.cnt    = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
        press_o = settle && level_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) r_q <= '0;
        else       r_q <= r_d;
    end
endmodule

// File: rtl/sdc_bcd_counter.sv
module sdc_bcd_counter
    import sdc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     clr_i,
    input  logic     inc_i,
    output bcd_num_t value_o
);
    bcd_num_t                cnt_d, cnt_q;
    logic [SDC_DIGITS:0]     lower_nines;

    assign lower_nines[0] = 1'b1;

    for (genvar g = 0; g < SDC_DIGITS; g++) begin : g_digit
        assign lower_nines[g+1] = lower_nines[g] && (cnt_q[g] == 4'd9);

        always_comb begin
            cnt_d[g] = cnt_q[g];
            if (clr_i) begin
                cnt_d[g] = 4'd0;
            end else if (inc_i && !lower_nines[SDC_DIGITS] && lower_nines[g]) begin
                cnt_d[g] = (cnt_q[g] == 4'd9) ? 4'd0 : cnt_q[g] + 4'd1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign value_o = cnt_q;
endmodule

// File: rtl/sonar_depth_ctrl.sv
module sonar_depth_ctrl
    import sdc_pkg::*;
#(
    parameter int LONG_TICKS  = 64,
    parameter int SHORT_TICKS = 8,
    parameter int DB_TICKS    = 4
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        pwr_btn_i,
    input  logic                        unit_btn_i,
    input  logic                        echo_i,
    output logic                        tx_en_o,
    output logic [SDC_DIGITS*SEG_W-1:0] seg_n_o,
    output logic                        led_ft_n_o,
    output logic                        led_m_n_o
);
    localparam int MAX_T = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int TW    = $clog2(MAX_T) + 1;

    typedef struct packed {
        sdc_state_e    state;
        logic          metric;
        logic [TW-1:0] timer;
        logic          echo_prev;
        bcd_num_t      depth;
        logic          err;
    } ctl_reg_t;

    ctl_reg_t   r_d, r_q;
    logic [2:0] synced;
    logic       pwr_press, unit_press, echo_edge;
    bcd_num_t   count;
    bcd_num_t   shown;
    sdc_state_e state_q;
    logic       err_q;

    sdc_sync2 #(.WIDTH(3)) sync_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .async_i({echo_i, unit_btn_i, pwr_btn_i}),
        .sync_o (synced)
    );

    sdc_debounce #(.DB_TICKS(DB_TICKS)) pwr_db_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .level_i(synced[0]),
        .press_o(pwr_press)
    );

    sdc_debounce #(.DB_TICKS(DB_TICKS)) unit_db_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .level_i(synced[1]),
        .press_o(unit_press)
    );

    sdc_bcd_counter cnt_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  ((r_q.state == ST_IDLE) || (r_q.state == ST_OFF)),
        .inc_i  ((r_q.state == ST_SEND) || (r_q.state == ST_RECV)),
        .value_o(count)
    );

    assign echo_edge = synced[2] && !r_q.echo_prev;

    always_comb begin
        r_d           = r_q;
        r_d.timer     = r_q.timer + 1'b1;
        r_d.echo_prev = synced[2];
        case (r_q.state)
            ST_OFF: begin
                if (pwr_press) begin
                    r_d.state = ST_IDLE;
                    r_d.timer = '0;
                    r_d.depth = '0;
                    r_d.err   = 1'b0;
                end
            end
            ST_IDLE: begin
                if (pwr_press) begin
                    r_d.state = ST_OFF;
                end else if (r_q.timer == TW'(LONG_TICKS - 1)) begin
                    r_d.state = ST_SEND;
                    r_d.timer = '0;
                end
            end
            ST_SEND: begin
                if (r_q.timer == TW'(SHORT_TICKS - 1)) begin
                    r_d.state = ST_RECV;
                    r_d.timer = '0;
                end
            end
            default: begin
                if (echo_edge) begin
                    r_d.state = ST_IDLE;
                    r_d.timer = '0;
                    r_d.depth = count;
                    r_d.err   = 1'b0;
                end else if (r_q.timer == TW'(LONG_TICKS - 1)) begin
                    r_d.state = ST_IDLE;
                    r_d.timer = '0;
                    r_d.err   = 1'b1;
                end
            end
        endcase
        if (r_q.state != ST_OFF && unit_press) begin
            r_d.metric = !r_q.metric;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q       <= '0;
            r_q.state <= ST_OFF;
        end else begin
            r_q <= r_d;
        end
    end

    // display path
    always_comb begin
        logic lead;
        shown = r_q.metric ? feet_to_meters(r_q.depth) : r_q.depth;
        lead  = 1'b1;
        for (int i = SDC_DIGITS - 1; i >= 0; i--) begin
            lead = lead && (shown[i] == 4'd0) && (i != 0);
            if (r_q.state == ST_OFF || lead)
                seg_n_o[i*SEG_W +: SEG_W] = SEG_BLANK_N;
            else if (r_q.err)
                seg_n_o[i*SEG_W +: SEG_W] = SEG_DASH_N;
            else
                seg_n_o[i*SEG_W +: SEG_W] = seg_of(shown[i]);
            if (r_q.err && r_q.state != ST_OFF)
                seg_n_o[i*SEG_W +: SEG_W] = SEG_DASH_N;
        end
    end

    assign tx_en_o    = (r_q.state == ST_SEND);
    assign led_ft_n_o = (r_q.state == ST_OFF) || r_q.metric;
    assign led_m_n_o  = (r_q.state == ST_OFF) || !r_q.metric;
    assign state_q    = r_q.state;
    assign err_q      = r_q.err;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
    import sdc_pkg::*;
#(
    parameter int SHORT_TICKS = 8
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input sdc_state_e                  state_i,
    input logic                        err_i,
    input logic                        tx_en_i,
    input logic [SDC_DIGITS*SEG_W-1:0] seg_n_i,
    input logic                        led_ft_n_i,
    input logic                        led_m_n_i
);
    localparam int RW = $clog2(SHORT_TICKS + 2) + 1;
    logic [RW-1:0] tx_run;

    always_ff @(posedge clk_i) begin
        if (rst_i)        tx_run <= '0;
        else if (tx_en_i) tx_run <= tx_run + 1'b1;
        else              tx_run <= '0;
    end

    // R1: off means every output dark
    a_r1_dark_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_OFF) |-> (&seg_n_i && led_ft_n_i && led_m_n_i && !tx_en_i));

    // R3: exactly one unit LED while on
    a_r3_one_led: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i != ST_OFF) |-> ($countones({led_ft_n_i, led_m_n_i}) == 1));

    // R4: each burst lasts SHORT_TICKS cycles
    a_r4_burst_len: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(tx_en_i) |-> (tx_run == RW'(SHORT_TICKS)));

    // R4: burst starts only out of the wait phase
    a_r4_burst_after_wait: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(tx_en_i) |-> ($past(state_i) == ST_IDLE));

    // R7: error mode shows dashes
    a_r7_dash_pattern: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_i && state_i != ST_OFF) |-> (seg_n_i == {SDC_DIGITS{SEG_DASH_N}}));

    // R2: switching off happens only from the wait phase
    a_r2_off_from_wait: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_OFF && $past(state_i) != ST_OFF) |-> ($past(state_i) == ST_IDLE));
endmodule

bind sonar_depth_ctrl sdc_checker #(.SHORT_TICKS(SHORT_TICKS)) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .state_i   (state_q),
    .err_i     (err_q),
    .tx_en_i   (tx_en_o),
    .seg_n_i   (seg_n_o),
    .led_ft_n_i(led_ft_n_o),
    .led_m_n_i (led_m_n_o)
);

// File: tb/sonar_depth_ctrl_tb_top.sv
module sonar_depth_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LONG  = 64;
    localparam int SHORT = 8;
    localparam int DB    = 4;

    logic        clk = 0, rst = 1;
    logic        pwr = 0, unit = 0, echo = 0;
    logic        tx_en, led_ft_n, led_m_n;
    logic [20:0] seg_n;

    int tests = 0, fails = 0, cycles = 0;

    sonar_depth_ctrl #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT), .DB_TICKS(DB)) dut_i (
        .clk_i(clk), .rst_i(rst), .pwr_btn_i(pwr), .unit_btn_i(unit), .echo_i(echo),
        .tx_en_o(tx_en), .seg_n_o(seg_n), .led_ft_n_o(led_ft_n), .led_m_n_o(led_m_n));

    always #(CLK_PERIOD/2) clk = ~clk;

    // digit code: -1 dark, -2 dash, else 0..9
    function automatic logic [6:0] dig(input int d);
        case (d)
            -1: return 7'h7F;
            -2: return 7'b0111111;
            0: return ~7'h3F;  1: return ~7'h06;  2: return ~7'h5B;
            3: return ~7'h4F;  4: return ~7'h66;  5: return ~7'h6D;
            6: return ~7'h7D;  7: return ~7'h07;  8: return ~7'h7F;
            default: return ~7'h6F;
        endcase
    endfunction

    function automatic logic [20:0] word(input int h, input int t, input int o);
        return {dig(h), dig(t), dig(o)};
    endfunction

    // behavioural reference model
    int m_state, m_metric, m_timer, m_count, m_depth, m_err;
    int pb1, pb2, pst, pcnt, ub1, ub2, ust, ucnt, e1, e2, ep;

    function automatic logic [20:0] model_seg();
        int v, h, t, o;
        if (m_state == 0) return {21{1'b1}};
        if (m_err != 0) return word(-2, -2, -2);
        v = m_metric ? (m_depth * 3048 + 5000) / 10000 : m_depth;
        h = v / 100; t = (v / 10) % 10; o = v % 10;
        if (h == 0) begin h = -1; if (t == 0) t = -1; end
        return word(h, t, o);
    endfunction

    always @(posedge clk) begin
        int pp, up, ed, old;
        if (rst) begin
            m_state = 0; m_metric = 0; m_timer = 0; m_count = 0; m_depth = 0; m_err = 0;
            pb1 = 0; pb2 = 0; pst = 0; pcnt = 0; ub1 = 0; ub2 = 0; ust = 0; ucnt = 0;
            e1 = 0; e2 = 0; ep = 0;
        end else begin
            pp = (pb2 != pst && pcnt == DB-1 && pb2 == 1);
            if (pb2 != pst) begin if (pcnt == DB-1) begin pst = pb2; pcnt = 0; end else pcnt++; end
            else pcnt = 0;
            pb2 = pb1; pb1 = pwr;
            up = (ub2 != ust && ucnt == DB-1 && ub2 == 1);
            if (ub2 != ust) begin if (ucnt == DB-1) begin ust = ub2; ucnt = 0; end else ucnt++; end
            else ucnt = 0;
            ub2 = ub1; ub1 = unit;
            ed = e2 && !ep; ep = e2; e2 = e1; e1 = echo;
            old = m_state;
            m_timer++;
            case (old)
                0: if (pp) begin m_state = 1; m_timer = 0; m_depth = 0; m_err = 0; end
                1: if (pp) m_state = 0;
                   else if (m_timer == LONG) begin m_state = 2; m_timer = 0; end
                2: if (m_timer == SHORT) begin m_state = 3; m_timer = 0; end
                default: if (ed) begin m_state = 1; m_timer = 0; m_depth = m_count; m_err = 0; end
                   else if (m_timer == LONG) begin m_state = 1; m_timer = 0; m_err = 1; end
            endcase
            if (old != 0 && up) m_metric = !m_metric;
            if (old == 2 || old == 3) begin if (m_count < 999) m_count++; end
            else m_count = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (tx_en !== (m_state == 2)) begin
                fails++; $display("FAIL R4 cycle %0d tx_en act=%b exp=%b", cycles, tx_en, m_state == 2);
            end
            if ({led_ft_n, led_m_n} !== {m_state == 0 || m_metric != 0, m_state == 0 || m_metric == 0}) begin
                fails++; $display("FAIL R3 cycle %0d leds act=%b%b", cycles, led_ft_n, led_m_n);
            end
            if (seg_n !== model_seg()) begin
                fails++; $display("FAIL R8 cycle %0d seg act=%h exp=%h", cycles, seg_n, model_seg());
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press_pwr(); pwr = 1; cyc(DB + 3); pwr = 0; cyc(DB + 3); endtask
    task automatic press_unit(); unit = 1; cyc(DB + 3); unit = 0; cyc(DB + 3); endtask

    task automatic wait_tx();
        for (int i = 0; i < 1000 && tx_en !== 1'b1; i++) @(negedge clk);
    endtask

    // echo raised in transmit-phase cycle d, returns measured burst length
    task automatic ping(input int d, output int ntx);
        wait_tx();
        ntx = 1;
        for (int i = 1; i <= d; i++) begin @(negedge clk); if (tx_en) ntx++; end
        echo = 1; cyc(5); echo = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ntx;
        cyc(4); rst = 0; @(negedge clk);
        chk(seg_n == {21{1'b1}} && led_ft_n && led_m_n && !tx_en, "R1 reset dark", {seg_n, led_ft_n, led_m_n}, '1);

        press_unit();
        chk({led_ft_n, led_m_n} == 2'b11, "R3 unit ignored when off", {led_ft_n, led_m_n}, 2'b11);

        press_pwr();
        chk({led_ft_n, led_m_n} == 2'b01, "R2 power on feet", {led_ft_n, led_m_n}, 2'b01);
        chk(seg_n == word(-1, -1, 0), "R11 cleared reading", seg_n, word(-1, -1, 0));

        pwr = 1; cyc(2); pwr = 0; cyc(10);
        chk(led_ft_n == 0, "R10 glitch ignored", led_ft_n, 0);

        ping(20, ntx);
        chk(ntx == SHORT, "R4 burst length", ntx, SHORT);
        cyc(3);
        chk(seg_n == word(-1, 2, 2), "R5 22 ft reading", seg_n, word(-1, 2, 2));

        press_unit();
        chk({led_ft_n, led_m_n} == 2'b10, "R3 toggled to meters", {led_ft_n, led_m_n}, 2'b10);
        chk(seg_n == word(-1, -1, 7), "R9 22 ft as 7 m", seg_n, word(-1, -1, 7));

        ping(40, ntx); cyc(3);
        chk(seg_n == word(-1, 1, 3), "R9 42 ft as 13 m", seg_n, word(-1, 1, 3));

        ping(2, ntx);
        for (int i = 0; i < 100 && tx_en; i++) @(negedge clk);
        cyc(LONG + 4);
        chk(seg_n == word(-2, -2, -2), "R7 timeout dashes", seg_n, word(-2, -2, -2));
        chk(tx_en == 0 && led_m_n == 0, "R6 send-phase echo ignored", {tx_en, led_m_n}, 0);

        ping(8, ntx); cyc(3);
        chk(seg_n == word(-1, -1, 3), "R8 blank 3 m", seg_n, word(-1, -1, 3));
        chk(seg_n != word(-2, -2, -2), "R7 error cleared", seg_n, word(-1, -1, 3));

        press_unit(); cyc(2);
        chk(seg_n == word(-1, 1, 0), "R8 10 ft blanking", seg_n, word(-1, 1, 0));

        press_pwr();
        chk(seg_n == {21{1'b1}} && led_ft_n && led_m_n, "R2 power off in wait", {seg_n, led_ft_n, led_m_n}, '1);

        press_pwr();
        chk(seg_n == word(-1, -1, 0) && led_ft_n == 0, "R11 power on clears, unit kept", seg_n, word(-1, -1, 0));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule